// File: doc/BRIEF.md
# Multi-core IRQ/FIQ interrupt router

This block collects every interrupt source of a four-core cluster and steers each one onto one core's IRQ or FIQ line. It takes these sources: one GPU IRQ line and one GPU FIQ line from an upstream controller, four timer lines per core, four mailbox pending flags per core, and one shared local-timer flag together with its enable. The timers and the mailbox storage sit elsewhere and arrive here only as level flags.

Software sets the steering through a 32-bit register port. It can choose which core takes the GPU IRQ, which core takes the GPU FIQ, and which core takes the shared local timer, either as IRQ or as FIQ. A control byte for each core enables each of that core's timer lines as IRQ or FIQ. Each core also has two read-only source words, one for IRQ and one for FIQ, that show which sources are active right now. A core's IRQ output is high whenever any bit of its IRQ source word is set, and FIQ works the same way. The source words are combinational on the inputs, so a change on an input reaches the outputs in the same cycle. A register write takes effect from the clock edge that captures it.

Top module: `irq_router`

## Requirements
- R1: After reset, every routing field and every per-core timer control byte reads 0, and with all inputs low every irq_o and fiq_o bit is 0.
- R2: The GPU routing word at offset 0x0C holds the GPU IRQ target core in bits [1:0] and the GPU FIQ target core in bits [3:2], and reads back as written in those 4 bits. While gpu_irq_i is high, bit 8 of the IRQ source word of the selected core is set, and that bit is set for no other core.
- R3: While gpu_fiq_i is high, bit 8 of the FIQ source word of the core selected by bits [3:2] of offset 0x0C is set, and for no other core.
- R4: The timer control byte of core c sits at offset 0x40+4c. It keeps bits [7:0] of a write and reads back 0 in bits [31:8].
- R5: Timer line j of core c is core_tmr_i bit 4c+j. In that core's control byte, bit j+4 enables the line as FIQ and bit j enables it as IRQ. When the FIQ enable is set, an active line sets FIQ source bit j of core c and never the IRQ bit. Otherwise, when the IRQ enable is set, it sets IRQ source bit j. With neither enable set it sets nothing.
- R6: Mailbox flag m of core c is mbox_pend_i bit 4c+m. It sets IRQ source bit 4+m of core c.
- R7: The local-timer routing word at offset 0x24 keeps 3 bits. Bits [1:0] select a core. Bit 2 set delivers the shared local timer on bit 11 of that core's FIQ source word; bit 2 clear delivers it on bit 11 of that core's IRQ source word.
- R8: The shared local timer is delivered only while lt_int_en_i and lt_pend_i are both high. Otherwise bit 11 is clear in every source word.
- R9: irq_o[c] is high exactly when core c's IRQ source word is nonzero, and fiq_o[c] is high exactly when its FIQ source word is nonzero. Bits 9, 10 and 12 to 31 of every source word are always 0.
- R10: Core c's IRQ source word reads at offset 0x60+4c and its FIQ source word at 0x70+4c. Writes to these offsets change no state.
- R11: Reads of unmapped or misaligned offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset for a read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| gpu_irq_i | input | 1 | GPU IRQ level from the upstream controller |
| gpu_fiq_i | input | 1 | GPU FIQ level from the upstream controller |
| core_tmr_i | input | 16 | Per-core timer lines, bit 4c+j |
| mbox_pend_i | input | 16 | Per-core mailbox pending flags, bit 4c+m |
| lt_int_en_i | input | 1 | Interrupt enable of the shared local timer |
| lt_pend_i | input | 1 | Pending flag of the shared local timer |
| irq_o | output | 4 | IRQ line per core |
| fiq_o | output | 4 | FIQ line per core |

## Verification
Some properties are checked on every cycle by assertions. A timer line is never present in both the IRQ and the FIQ word of a core. The GPU IRQ reaches exactly one core while it is raised. The local-timer bit stays absent unless both its enable and its pending flag are high. A write to an unmapped or read-only offset leaves the configuration unchanged. Both outputs stay low while every source is idle. Other behaviour can only be shown by the bench's scenarios: that each routing field selects the intended core, the bit position each source lands on, the exact read-back values, and that the control byte truncates wider writes.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    // register offsets (bytes)
    localparam int OFS_GPU_ROUTE = 'h0C;
    localparam int OFS_LT_ROUTE  = 'h24;
    localparam int OFS_TCTL      = 'h40;
    localparam int OFS_ISRC      = 'h60;
    localparam int OFS_FSRC      = 'h70;
    localparam int REG_STRIDE    = 4;

    // source bit positions inside a per-core source word
    localparam int SRC_W         = 32;
    localparam int BIT_MBOX_BASE = 4;
    localparam int BIT_GPU       = 8;
    localparam int BIT_LTMR      = 11;
endpackage

// File: rtl/irq_router_regs.sv
module irq_router_regs
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TMR_LINES = 4,
    parameter int AW        = 8,
    parameter int DW        = 32,
    localparam int CW       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int TCTL_W   = 2 * TMR_LINES
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   wr_en,
    input  logic [AW-1:0]                          addr,
    input  logic [DW-1:0]                          wdata,
    output logic [DW-1:0]                          rdata,
    input  logic [NUM_CORES-1:0][SRC_W-1:0]        irq_src,
    input  logic [NUM_CORES-1:0][SRC_W-1:0]        fiq_src,
    output logic [CW-1:0]                          gpu_irq_core,
    output logic [CW-1:0]                          gpu_fiq_core,
    output logic [CW-1:0]                          lt_core,
    output logic                                   lt_fiq,
    output logic [NUM_CORES-1:0][TCTL_W-1:0]       tctl
);
    typedef struct packed {
        logic [CW-1:0]                    gpu_irq_core;
        logic [CW-1:0]                    gpu_fiq_core;
        logic [CW-1:0]                    lt_core;
        logic                             lt_fiq;
        logic [NUM_CORES-1:0][TCTL_W-1:0] tctl;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic cfg_hit;   // address selects a writable configuration field

    always_comb begin
        cfg_d   = cfg_q;
        rdata   = '0;
        cfg_hit = 1'b0;
        if (addr == AW'(OFS_GPU_ROUTE)) begin
            cfg_hit = 1'b1;
            rdata   = DW'({cfg_q.gpu_fiq_core, cfg_q.gpu_irq_core});
            if (wr_en) begin
                cfg_d.gpu_irq_core = wdata[CW-1:0];
                cfg_d.gpu_fiq_core = wdata[2*CW-1:CW];
            end
        end
        if (addr == AW'(OFS_LT_ROUTE)) begin
            cfg_hit = 1'b1;
            rdata   = DW'({cfg_q.lt_fiq, cfg_q.lt_core});
            if (wr_en) begin
                cfg_d.lt_core = wdata[CW-1:0];
                cfg_d.lt_fiq  = wdata[CW];
            end
        end
        for (int c = 0; c < NUM_CORES; c++) begin
            if (addr == AW'(OFS_TCTL + REG_STRIDE * c)) begin
                cfg_hit = 1'b1;
                rdata   = DW'(cfg_q.tctl[c]);
                if (wr_en) cfg_d.tctl[c] = wdata[TCTL_W-1:0];
            end
            if (addr == AW'(OFS_ISRC + REG_STRIDE * c)) rdata = DW'(irq_src[c]);
            if (addr == AW'(OFS_FSRC + REG_STRIDE * c)) rdata = DW'(fiq_src[c]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign gpu_irq_core = cfg_q.gpu_irq_core;
    assign gpu_fiq_core = cfg_q.gpu_fiq_core;
    assign lt_core      = cfg_q.lt_core;
    assign lt_fiq       = cfg_q.lt_fiq;
    assign tctl         = cfg_q.tctl;

    // write to a read-only or unmapped offset leaves configuration alone (R10, R11)
    assert_ignored_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_hit) |=> $stable(cfg_q))
        else $error("write to non-configuration offset changed state");
endmodule

// File: rtl/irq_router_steer.sv
module irq_router_steer
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TMR_LINES = 4,
    parameter int MBOX      = 4,
    localparam int CW       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int TCTL_W   = 2 * TMR_LINES
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [CW-1:0]                          gpu_irq_core,
    input  logic [CW-1:0]                          gpu_fiq_core,
    input  logic [CW-1:0]                          lt_core,
    input  logic                                   lt_fiq,
    input  logic [NUM_CORES-1:0][TCTL_W-1:0]       tctl,
    input  logic                                   gpu_irq,
    input  logic                                   gpu_fiq,
    input  logic [NUM_CORES-1:0][TMR_LINES-1:0]    tmr,
    input  logic [NUM_CORES-1:0][MBOX-1:0]         mbox,
    input  logic                                   lt_en,
    input  logic                                   lt_pend,
    output logic [NUM_CORES-1:0][SRC_W-1:0]        irq_src,
    output logic [NUM_CORES-1:0][SRC_W-1:0]        fiq_src
);
    localparam logic [SRC_W-1:0] TMR_MASK = SRC_W'((1 << TMR_LINES) - 1);

    logic lt_live;
    logic [NUM_CORES-1:0] gpu_irq_hits;
    logic [NUM_CORES-1:0] lt_hits;

    assign lt_live = lt_en && lt_pend;

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        always_comb begin
            irq_src[c] = '0;
            fiq_src[c] = '0;
            for (int j = 0; j < TMR_LINES; j++) begin
                if (tmr[c][j]) begin
                    if (tctl[c][j + TMR_LINES]) fiq_src[c][j] = 1'b1;
                    else if (tctl[c][j])        irq_src[c][j] = 1'b1;
                end
            end
            for (int m = 0; m < MBOX; m++) begin
                irq_src[c][BIT_MBOX_BASE + m] = mbox[c][m];
            end
            if (gpu_irq && gpu_irq_core == CW'(c)) irq_src[c][BIT_GPU] = 1'b1;
            if (gpu_fiq && gpu_fiq_core == CW'(c)) fiq_src[c][BIT_GPU] = 1'b1;
            if (lt_live && lt_core == CW'(c)) begin
                if (lt_fiq) fiq_src[c][BIT_LTMR] = 1'b1;
                else        irq_src[c][BIT_LTMR] = 1'b1;
            end
        end
        assign gpu_irq_hits[c] = irq_src[c][BIT_GPU];
        assign lt_hits[c]      = irq_src[c][BIT_LTMR] | fiq_src[c][BIT_LTMR];

        // a timer line never lands in both words of one core (R5)
        assert_fiq_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_src[c] & fiq_src[c] & TMR_MASK) == '0)
            else $error("timer line delivered as both IRQ and FIQ");
    end

    // GPU IRQ reaches exactly one core while raised (R2)
    assert_gpu_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gpu_irq_hits) == (gpu_irq ? 1 : 0))
        else $error("GPU IRQ delivered to wrong number of cores");

    // local timer gated by enable and pending (R8)
    assert_lt_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(lt_en && lt_pend) |-> (lt_hits == '0))
        else $error("local timer delivered without enable and pending");
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int TMR_LINES = 4,
    parameter int MBOX      = 4,
    parameter int AW        = 8,
    parameter int DW        = 32,
    localparam int CW       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
    localparam int TCTL_W   = 2 * TMR_LINES
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [AW-1:0]                   reg_addr,
    input  logic [DW-1:0]                   reg_wdata,
    output logic [DW-1:0]                   reg_rdata,
    input  logic                            gpu_irq_i,
    input  logic                            gpu_fiq_i,
    input  logic [NUM_CORES*TMR_LINES-1:0]  core_tmr_i,
    input  logic [NUM_CORES*MBOX-1:0]       mbox_pend_i,
    input  logic                            lt_int_en_i,
    input  logic                            lt_pend_i,
    output logic [NUM_CORES-1:0]            irq_o,
    output logic [NUM_CORES-1:0]            fiq_o
);
    logic [CW-1:0]                       gpu_irq_core, gpu_fiq_core, lt_core;
    logic                                lt_fiq;
    logic [NUM_CORES-1:0][TCTL_W-1:0]    tctl;
    logic [NUM_CORES-1:0][SRC_W-1:0]     irq_src, fiq_src;
    logic [NUM_CORES-1:0][TMR_LINES-1:0] tmr_2d;
    logic [NUM_CORES-1:0][MBOX-1:0]      mbox_2d;

    assign tmr_2d  = core_tmr_i;
    assign mbox_2d = mbox_pend_i;

    irq_router_regs #(
        .NUM_CORES(NUM_CORES), .TMR_LINES(TMR_LINES), .AW(AW), .DW(DW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .irq_src(irq_src), .fiq_src(fiq_src),
        .gpu_irq_core(gpu_irq_core), .gpu_fiq_core(gpu_fiq_core),
        .lt_core(lt_core), .lt_fiq(lt_fiq), .tctl(tctl)
    );

    irq_router_steer #(
        .NUM_CORES(NUM_CORES), .TMR_LINES(TMR_LINES), .MBOX(MBOX)
    ) u_steer (
        .clk(clk), .rst_n(rst_n),
        .gpu_irq_core(gpu_irq_core), .gpu_fiq_core(gpu_fiq_core),
        .lt_core(lt_core), .lt_fiq(lt_fiq), .tctl(tctl),
        .gpu_irq(gpu_irq_i), .gpu_fiq(gpu_fiq_i),
        .tmr(tmr_2d), .mbox(mbox_2d),
        .lt_en(lt_int_en_i), .lt_pend(lt_pend_i),
        .irq_src(irq_src), .fiq_src(fiq_src)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_out
        assign irq_o[c] = |irq_src[c];
        assign fiq_o[c] = |fiq_src[c];
    end

    // idle sources give idle outputs (R9)
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpu_irq_i && !gpu_fiq_i && core_tmr_i == '0 && mbox_pend_i == '0 && !lt_pend_i)
        |-> (irq_o == '0 && fiq_o == '0))
        else $error("interrupt output active with no source");
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/1ps
module sim_irq_router;
    localparam logic [7:0] A_GPU = 8'h0C, A_LT = 8'h24, A_TCTL = 8'h40,
                           A_ISRC = 8'h60, A_FSRC = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        gpu_irq_i = 1'b0, gpu_fiq_i = 1'b0;
    logic [15:0] core_tmr_i = '0, mbox_pend_i = '0;
    logic        lt_int_en_i = 1'b0, lt_pend_i = 1'b0;
    logic [3:0]  irq_o, fiq_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpu_irq_i(gpu_irq_i), .gpu_fiq_i(gpu_fiq_i),
        .core_tmr_i(core_tmr_i), .mbox_pend_i(mbox_pend_i),
        .lt_int_en_i(lt_int_en_i), .lt_pend_i(lt_pend_i),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    typedef struct packed {
        logic [3:0]  gpu_rt;
        logic [2:0]  lt_rt;
        logic [31:0] tctl;     // core3..core0 bytes
        logic        gi, gf;
        logic [15:0] tmr, mbox;
        logic        le, lp;
        logic [3:0]  e_irq, e_fiq;
        logic [1:0]  chk;
        logic [15:0] e_is, e_fs;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{4'h0, 3'h0, 32'h0,          1'b0, 1'b0, 16'h0,    16'h0,    1'b0, 1'b0, 4'h0, 4'h0, 2'd0, 16'h000, 16'h000}, // R9 idle
        '{4'hE, 3'h0, 32'h0,          1'b1, 1'b1, 16'h0,    16'h0,    1'b0, 1'b0, 4'h4, 4'h8, 2'd2, 16'h100, 16'h000}, // R2 R3
        '{4'hE, 3'h0, 32'h0,          1'b1, 1'b0, 16'h0,    16'h0,    1'b0, 1'b0, 4'h4, 4'h0, 2'd3, 16'h000, 16'h000}, // R3
        '{4'h0, 3'h0, 32'h0000_2100,  1'b0, 1'b0, 16'h0070, 16'h0,    1'b0, 1'b0, 4'h2, 4'h2, 2'd1, 16'h001, 16'h002}, // R5
        '{4'h0, 3'h0, 32'h0000_0011,  1'b0, 1'b0, 16'h0001, 16'h0,    1'b0, 1'b0, 4'h0, 4'h1, 2'd0, 16'h000, 16'h001}, // R5 prio
        '{4'h0, 3'h0, 32'h0,          1'b0, 1'b0, 16'h0,    16'h0A00, 1'b0, 1'b0, 4'h4, 4'h0, 2'd2, 16'h0A0, 16'h000}, // R6
        '{4'h0, 3'h3, 32'h0,          1'b0, 1'b0, 16'h0,    16'h0,    1'b1, 1'b1, 4'h8, 4'h0, 2'd3, 16'h800, 16'h000}, // R7 irq
        '{4'h0, 3'h5, 32'h0,          1'b0, 1'b0, 16'h0,    16'h0,    1'b1, 1'b1, 4'h0, 4'h2, 2'd1, 16'h000, 16'h800}, // R7 fiq
        '{4'h0, 3'h5, 32'h0,          1'b0, 1'b0, 16'h0,    16'h0,    1'b1, 1'b0, 4'h0, 4'h0, 2'd1, 16'h000, 16'h000}, // R8
        '{4'h0, 3'h5, 32'h0,          1'b0, 1'b0, 16'h0,    16'h0,    1'b0, 1'b1, 4'h0, 4'h0, 2'd1, 16'h000, 16'h000}, // R8
        '{4'h0, 3'h0, 32'h0000_0008,  1'b1, 1'b1, 16'h0008, 16'h0,    1'b0, 1'b0, 4'h1, 4'h1, 2'd0, 16'h108, 16'h100}  // R9 mix
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_GPU, v); check("R1 gpu route", v, 0);
        rd(A_LT, v);  check("R1 lt route", v, 0);
        for (int c = 0; c < 4; c++) begin
            rd(8'(A_TCTL + 4 * c), v); check("R1 tctl", v, 0);
        end
        #1 check("R1 outputs", {24'h0, fiq_o, irq_o}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            wr(A_GPU, 32'(VECS[i].gpu_rt));
            wr(A_LT, 32'(VECS[i].lt_rt));
            for (int c = 0; c < 4; c++) wr(8'(A_TCTL + 4 * c), 32'(VECS[i].tctl[8*c +: 8]));
            @(negedge clk);
            gpu_irq_i = VECS[i].gi; gpu_fiq_i = VECS[i].gf;
            core_tmr_i = VECS[i].tmr; mbox_pend_i = VECS[i].mbox;
            lt_int_en_i = VECS[i].le; lt_pend_i = VECS[i].lp;
            #1;
            check("R9 irq_o", 32'(irq_o), 32'(VECS[i].e_irq));
            check("R9 fiq_o", 32'(fiq_o), 32'(VECS[i].e_fiq));
            rd(8'(A_ISRC + 4 * VECS[i].chk), v); check("R10 irq source word", v, 32'(VECS[i].e_is));
            rd(8'(A_FSRC + 4 * VECS[i].chk), v); check("R10 fiq source word", v, 32'(VECS[i].e_fs));
            rd(A_GPU, v); check("R2 gpu route readback", v, 32'(VECS[i].gpu_rt));
            rd(A_LT, v);  check("R7 lt route readback", v, 32'(VECS[i].lt_rt));
        end

        // R4 control byte truncation
        wr(8'(A_TCTL + 8), 32'hFFFF_FFA5);
        rd(8'(A_TCTL + 8), v); check("R4 tctl truncation", v, 32'h0000_00A5);
        wr(8'(A_TCTL + 8), 32'h0);

        // R10 writes to source words ignored; last vector still applied
        wr(A_ISRC, 32'hFFFF_FFFF);
        wr(A_FSRC, 32'hFFFF_FFFF);
        rd(A_ISRC, v); check("R10 isrc after write", v, 32'h108);
        rd(A_FSRC, v); check("R10 fsrc after write", v, 32'h100);
        rd(A_GPU, v);  check("R10 gpu route untouched", v, 0);

        // R11 unmapped and misaligned offsets
        wr(A_GPU, 32'h9); wr(A_LT, 32'h6); wr(A_TCTL, 32'h3C);
        wr(8'h00, 32'hFFFF_FFFF); wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h0D, 32'hFFFF_FFFF); wr(8'h41, 32'hFFFF_FFFF); wr(8'hFC, 32'hFFFF_FFFF);
        rd(A_GPU, v);  check("R11 gpu route kept", v, 32'h9);
        rd(A_LT, v);   check("R11 lt route kept", v, 32'h6);
        rd(A_TCTL, v); check("R11 tctl kept", v, 32'h3C);
        rd(8'h00, v);  check("R11 unmapped read", v, 0);
        rd(8'h0D, v);  check("R11 misaligned read", v, 0);
        rd(8'h30, v2); check("R11 unmapped read 0x30", v2, 0);

        // R6 mailbox on core 0 with R2 routing away to core 1
        @(negedge clk);
        gpu_irq_i = 1'b1; gpu_fiq_i = 1'b0; core_tmr_i = '0; mbox_pend_i = 16'h0001;
        lt_int_en_i = 1'b0; lt_pend_i = 1'b0;
        rd(A_ISRC, v);      check("R6 core0 mailbox bit", v, 32'h010);
        rd(A_ISRC + 4, v);  check("R2 core1 gpu bit", v, 32'h100);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule